// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits between a transmit cell buffer and a serial line framer. Every clock it emits one byte of a continuous 53-byte cell stream, marking the first byte of each cell. At each cell boundary it looks at the buffer's cell-available flag. If a whole cell is waiting, it reads that cell byte by byte. If not, it builds a fill cell from a fixed template whose header type is chosen by a control input.

On the way out, each cell gets its header check byte computed and, optionally, written over byte 4. A coset constant can be folded into that byte. The 48 payload bytes can be scrambled by a self-synchronizing x^43+1 scrambler. For link diagnostics, an armed error injector damages the check byte of every Nth cell until a programmed number of damaged cells has been sent. A saturating counter records how many buffer cells were consumed. A latch-and-clear strobe copies the counter to an output and restarts it. A global processing enable turns every one of these operations off, so the bytes go through untouched.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: Output is one byte per clock in 53-byte cells. `out_soc` is high with byte 0 of each cell only. Each output byte appears one clock after the cycle in which its source byte was taken.
- R2: `in_cav` is sampled only in the first cycle of a cell. If it is high, `in_rd` stays high for all 53 cycles of that cell and `in_data` is consumed in each of them. If it is low, `in_rd` stays low for the whole cell.
- R3: A fill cell has header bytes 0..3 equal to 00 00 00 01 when `fill_idle`=1, or 00 00 00 00 when `fill_idle`=0. Its payload bytes 5..52 are 0x6A before scrambling. While processing is on, byte 4 of a fill cell always carries the computed check byte.
- R4: The check byte is the CRC-8 remainder over header bytes 0..3, using generator x^8+x^2+x+1, bits taken most significant first, starting from zero. When `hec_wr`=1, it replaces byte 4 of a buffer cell. When `hec_wr`=0, the buffer's byte 4 is kept.
- R5: When `coset_en`=1, 0x55 is XORed into the computed check byte before it is used.
- R6: When `scr_en`=1, payload bytes 5..52 are scrambled bit-serially, most significant bit first. Each output bit equals the input bit XOR the output bit produced 43 bits earlier. Header bytes are never scrambled. The scrambler history is all ones after reset, carries over from cell to cell, and advances only on scrambled bytes.
- R7: A pulse on `err_arm` loads the remaining-error count from `err_total` and restarts the period count. While processing is on, each cell start counts one cell. Every `err_rate`-th cell has byte 4 XORed with 0x01 (`err_multi`=0) or 0x05 (`err_multi`=1). Injection stops once the remaining count reaches zero. `err_rate`=0 disables injection.
- R8: An internal counter of CNT_W bits counts buffer cells read, not fill cells, and saturates at its all-ones value.
- R9: A pulse on `cnt_take` copies the counter to `cell_cnt` on the next clock. The counter then restarts from zero, or from one if a buffer cell starts in that same cycle.
- R10: With `proc_en`=0, the output byte is the source byte unchanged. A fill cell then carries 0x00 in byte 4. No scrambling or error injection takes place, and the scrambler history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_en | input | 1 | Enable all cell processing (0 = bypass) |
| hec_wr | input | 1 | Write computed check byte into buffer cells |
| coset_en | input | 1 | XOR coset 0x55 into check byte |
| scr_en | input | 1 | Scramble payload bytes |
| fill_idle | input | 1 | Fill header type: 1 idle, 0 unassigned |
| err_multi | input | 1 | Injected error mask: 0 single bit, 1 two bits |
| err_rate | input | RATE_W | Cells per injected error (0 = off) |
| err_total | input | EC_W | Number of cells to damage |
| err_arm | input | 1 | Load error injector |
| cnt_take | input | 1 | Latch counter to output and clear it |
| in_cav | input | 1 | Buffer holds a whole cell |
| in_data | input | 8 | Buffer head byte |
| in_rd | output | 1 | Consume buffer head byte |
| out_data | output | 8 | Line byte |
| out_soc | output | 1 | First byte of cell |
| cell_cnt | output | CNT_W | Latched count of buffer cells |

## Verification
The hardest situation to reach is a saturated cell counter, together with a latch strobe that arrives in the same cycle as a new buffer cell begins. The bench builds the design with a narrow counter and queues more cells than the counter can hold. It then times the strobe to land on a cell boundary while another cell is waiting. Error injection across rate and count limits, and scrambler continuity through a bypass interval, are reached by arming the injector and toggling enables between long runs of queued cells. The reference model follows all of these every clock.

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc #(
  parameter int CNT_W = 32,
  parameter int RATE_W = 8,
  parameter int EC_W = 8,
  parameter logic [7:0] FILL_PAYLOAD = 8'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_en,
  input  logic              hec_wr,
  input  logic              coset_en,
  input  logic              scr_en,
  input  logic              fill_idle,
  input  logic              err_multi,
  input  logic [RATE_W-1:0] err_rate,
  input  logic [EC_W-1:0]   err_total,
  input  logic              err_arm,
  input  logic              cnt_take,
  input  logic              in_cav,
  input  logic [7:0]        in_data,
  output logic              in_rd,
  output logic [7:0]        out_data,
  output logic              out_soc,
  output logic [CNT_W-1:0]  cell_cnt
);

  localparam logic [5:0] LAST = 6'd52;
  localparam logic [7:0] COSET = 8'h55;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [50:0] scr_step(input logic [42:0] s, input logic [7:0] d);
    logic [42:0] st;
    logic [7:0] o;
    st = s;
    for (int i = 7; i >= 0; i--) begin
      o[i] = d[i] ^ st[42];
      st = {st[41:0], o[i]};
    end
    return {st, o};
  endfunction

  logic [5:0]        pos;
  logic              fill_q, hit_q;
  logic [7:0]        crc;
  logic [42:0]       scr;
  logic [EC_W-1:0]   left;
  logic [RATE_W-1:0] pc;
  logic [CNT_W-1:0]  cnt;

  logic              start, cur_fill, cur_hit, hit_now, err_live, inc, payload;
  logic [7:0]        tmpl, src, hec, ob, scr_byte;
  logic [42:0]       scr_nx;

  assign start    = (pos == 6'd0);
  assign cur_fill = start ? !in_cav : fill_q;
  assign in_rd    = !cur_fill;
  assign err_live = proc_en && (left != '0) && (err_rate != '0);
  assign hit_now  = err_live && (pc >= err_rate - RATE_W'(1));
  assign cur_hit  = start ? hit_now : hit_q;
  assign inc      = start && in_cav;
  assign payload  = (pos >= 6'd5);

  assign tmpl = (pos == 6'd3) ? {7'd0, fill_idle} : payload ? FILL_PAYLOAD : 8'h00;
  assign src  = cur_fill ? tmpl : in_data;
  assign hec  = crc ^ (coset_en ? COSET : 8'h00);
  assign {scr_nx, scr_byte} = scr_step(scr, src);

  always_comb begin
    ob = src;
    if (proc_en) begin
      if (pos == 6'd4)
        ob = ((hec_wr || cur_fill) ? hec : src) ^
             (cur_hit ? (err_multi ? 8'h05 : 8'h01) : 8'h00);
      else if (payload && scr_en)
        ob = scr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      fill_q   <= 1'b1;
      hit_q    <= 1'b0;
      crc      <= '0;
      scr      <= '1;
      out_data <= '0;
      out_soc  <= 1'b0;
    end else begin
      pos      <= (pos == LAST) ? 6'd0 : pos + 6'd1;
      out_data <= ob;
      out_soc  <= start;
      if (start) begin
        fill_q <= !in_cav;
        hit_q  <= hit_now;
      end
      if (pos < 6'd4) crc <= crc8(start ? 8'h00 : crc, src);
      if (proc_en && scr_en && payload) scr <= scr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      pc   <= '0;
    end else if (err_arm) begin
      left <= err_total;
      pc   <= '0;
    end else if (start && err_live) begin
      if (hit_now) begin
        pc   <= '0;
        left <= left - EC_W'(1);
      end else begin
        pc <= pc + RATE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cell_cnt <= '0;
    end else if (cnt_take) begin
      cell_cnt <= cnt;
      cnt      <= CNT_W'(inc);
    end else if (inc && cnt != '1) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/atm_tx_cell_proc_chk.sv
module atm_tx_cell_proc_chk #(
  parameter int CNT_W = 32,
  parameter int EC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proc_en,
  input logic             in_cav,
  input logic [7:0]       in_data,
  input logic             in_rd,
  input logic [7:0]       out_data,
  input logic             out_soc,
  input logic             err_arm,
  input logic             cnt_take,
  input logic [5:0]       pos,
  input logic [EC_W-1:0]  left,
  input logic [CNT_W-1:0] cnt,
  input logic [42:0]      scr
);

  p_soc_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |=> !out_soc);

  p_fill_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == 6'd0 && !in_cav) |-> !in_rd);

  p_read_whole_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != 6'd0) |-> (in_rd == $past(in_rd)));

  p_left_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !err_arm |=> (left <= $past(left)));

  p_cnt_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CNT_W{1'b1}} && !cnt_take) |=> (cnt == {CNT_W{1'b1}}));

  p_bypass_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_en && in_rd) |=> (out_data == $past(in_data)));

  p_bypass_scr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_en |=> (scr == $past(scr)));

endmodule

bind atm_tx_cell_proc atm_tx_cell_proc_chk #(.CNT_W(CNT_W), .EC_W(EC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .in_cav(in_cav), .in_data(in_data),
  .in_rd(in_rd), .out_data(out_data), .out_soc(out_soc), .err_arm(err_arm),
  .cnt_take(cnt_take), .pos(pos), .left(left), .cnt(cnt), .scr(scr)
);

// File: tb/atm_tx_cell_proc_tb.sv
module atm_tx_cell_proc_tb;
  localparam int CW = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic proc_en = 1'b1, hec_wr = 1'b1, coset_en = 1'b1, scr_en = 1'b1;
  logic fill_idle = 1'b1, err_multi = 1'b0, err_arm = 1'b0, cnt_take = 1'b0;
  logic [7:0] err_rate = '0, err_total = '0;
  logic in_cav = 1'b0;
  logic [7:0] in_data = '0;
  logic in_rd, out_soc;
  logic [7:0] out_data;
  logic [CW-1:0] cell_cnt;

  atm_tx_cell_proc #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .hec_wr(hec_wr), .coset_en(coset_en),
    .scr_en(scr_en), .fill_idle(fill_idle), .err_multi(err_multi), .err_rate(err_rate),
    .err_total(err_total), .err_arm(err_arm), .cnt_take(cnt_take), .in_cav(in_cav),
    .in_data(in_data), .in_rd(in_rd), .out_data(out_data), .out_soc(out_soc),
    .cell_cnt(cell_cnt)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] fq[$];

  int mpos = 0, mleft = 0, mpc = 0, mcnt = 0, mlat = 0;
  bit mfill = 1'b1, mhit = 1'b0, took = 1'b0;
  logic [7:0] hdr[4];
  bit hist[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] hec_of(logic [31:0] h);
    logic [39:0] v;
    v = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v = v ^ (40'h107 << (i - 8));
    return v[7:0];
  endfunction

  task automatic push_cell();
    for (int i = 0; i < 53; i++) fq.push_back(8'($urandom));
  endtask

  task automatic step();
    logic [7:0] src, ob, e_data;
    bit rd, hitnow, e_soc;
    string tag;
    int e_lat;
    in_cav  = (fq.size() >= 53);
    in_data = (fq.size() > 0) ? fq[0] : 8'h00;
    #1;
    if (mpos == 0) begin
      mfill = !in_cav;
      hitnow = proc_en && mleft > 0 && err_rate > 0 && mpc >= int'(err_rate) - 1;
      mhit = hitnow;
    end else hitnow = 1'b0;
    if (err_arm) begin
      mleft = err_total; mpc = 0;
    end else if (mpos == 0 && proc_en && mleft > 0 && err_rate > 0) begin
      if (hitnow) begin mpc = 0; mleft--; end else mpc++;
    end
    rd = !mfill;
    chk("R2 in_rd", in_rd, rd);
    if (mfill) src = (mpos == 3) ? {7'd0, fill_idle} : (mpos >= 5) ? 8'h6A : 8'h00;
    else src = in_data;
    if (mpos < 4) hdr[mpos] = src;
    ob = src;
    tag = mfill ? "R3 fill byte" : "R1 byte";
    if (!proc_en) tag = "R10 bypass byte";
    else if (mpos == 4) begin
      logic [7:0] h;
      h = hec_of({hdr[0], hdr[1], hdr[2], hdr[3]}) ^ (coset_en ? 8'h55 : 8'h00);
      ob = (hec_wr || mfill) ? h : src;
      if (mhit) ob = ob ^ (err_multi ? 8'h05 : 8'h01);
      tag = mhit ? "R7 injected hec" : coset_en ? "R5 coset hec" : "R4 hec";
    end else if (mpos >= 5 && scr_en) begin
      for (int b = 7; b >= 0; b--) begin
        bit o;
        o = src[b] ^ hist[0];
        void'(hist.pop_front());
        hist.push_back(o);
        ob[b] = o;
      end
      tag = "R6 payload";
    end
    if (cnt_take) begin
      mlat = mcnt; mcnt = (mpos == 0 && in_cav) ? 1 : 0; took = 1'b1;
    end else if (mpos == 0 && in_cav && mcnt < MAXC) mcnt++;
    e_data = ob; e_soc = (mpos == 0); e_lat = mlat;
    mpos = (mpos + 1) % 53;
    @(posedge clk);
    if (rd && fq.size() > 0) void'(fq.pop_front());
    @(negedge clk);
    chk(tag, out_data, e_data);
    chk("R1 soc", out_soc, e_soc);
    chk(took ? "R9 latched count" : "R8 count", cell_cnt, e_lat);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic take_pulse();
    cnt_take = 1'b1; step(); cnt_take = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 43; i++) hist.push_back(1'b1);
    repeat (3) @(negedge clk);
    chk("R1 reset soc", out_soc, 0);
    chk("R1 reset data", out_data, 0);
    chk("R8 reset count", cell_cnt, 0);
    rst_n = 1'b1;
    run(106);
    fill_idle = 1'b0; run(53);
    repeat (3) push_cell();
    run(159);
    hec_wr = 1'b0; coset_en = 1'b0; scr_en = 1'b0;
    repeat (2) push_cell();
    run(159);
    hec_wr = 1'b1; coset_en = 1'b1; scr_en = 1'b1; fill_idle = 1'b1;
    repeat (4) push_cell();
    err_rate = 8'd2; err_total = 8'd3; err_arm = 1'b1; step(); err_arm = 1'b0;
    run(8 * 53 - 1);
    err_multi = 1'b1; err_rate = 8'd1; err_total = 8'd2; err_arm = 1'b1; step(); err_arm = 1'b0;
    push_cell();
    run(3 * 53 - 1);
    push_cell();
    take_pulse(); run(52);
    proc_en = 1'b0;
    repeat (2) push_cell();
    err_arm = 1'b1; step(); err_arm = 1'b0;
    run(3 * 53 - 1);
    proc_en = 1'b1; run(53);
    repeat (34) push_cell();
    run(35 * 53);
    push_cell();
    take_pulse(); run(52 + 53);
    take_pulse(); run(52);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule